// File: doc/BRIEF.md
# Mixed-Policy Batch Arbiter for a Staged Memory Scheduler

The arbiter sits between a per-source batch former and a set of per-bank request queues. Each source (a CPU core or the GPU) presents the head request of its oldest formed batch. Whenever no batch is in flight, the arbiter selects one source. It then forwards that source's requests one per cycle, in order, into the bank queue named by each request's bank field, until the request marked as last of the batch has gone.

Each selection first makes a policy draw. An 8-bit linear feedback shift register is compared against a probability byte that software writes. When the register value is below the byte, the selection is shortest-job-first: the ready source with the fewest outstanding requests wins. Otherwise it is round-robin: the first ready source at or after a rotating pointer wins. A byte of 0 gives pure rotation, and a byte around 230 makes shortest-job-first the usual outcome. The outstanding counts are kept inside the block. A count rises when the batch former takes a request for that source and falls when the arbiter forwards one.

Top module: `sms_batch_arbiter`

## Requirements
- R1: After reset the block is idle: `gnt_busy`, `pop` and `bank_push` are all zero, the rotation pointer is 0, every outstanding count is 0 and the draw register holds 8'h01.
- R2: A batch is granted only to a source whose `hd_valid` bit is set in the cycle of the decision.
- R3: At each decision the policy is shortest-job-first exactly when the draw register value is less than `sjf_prob` (unsigned 8-bit). `gnt_sjf` shows the chosen policy while the batch drains. The register then advances once, to {q[6:0], q[7]^q[5]^q[4]^q[3]}. It never advances between decisions.
- R4: With `sjf_prob` = 0, every decision uses round-robin.
- R5: Under shortest-job-first, the grant goes to the ready source with the smallest outstanding count. On a tie, the lowest index wins.
- R6: Under round-robin, the grant goes to the first ready source found by scanning upward, cyclically, from the pointer. After every grant, under either policy, the pointer becomes the granted index plus one, modulo the number of sources.
- R7: While a batch drains, `gnt_src` is stable and only that source is popped, at most once per cycle and in order. After the pop of the request with `hd_last` set, `gnt_busy` is low for at least one cycle before the next grant. While idle, nothing is popped or pushed.
- R8: Each forwarded request pulses exactly the `bank_push` bit whose index equals the request's bank field, together with the pop. `fwd_data` carries the request's `hd_data` unchanged.
- R9: When the bank named by the granted head request has `bank_full` set, neither a pop nor a push happens in that cycle, and the drain resumes once the bank is no longer full.
- R10: A source's outstanding count rises by one for each cycle its `enq` bit is set and falls by one for each request forwarded from it. Both in one cycle leave it unchanged.
- R11: With `sjf_prob` = 230, at least 70% of a run of decisions use shortest-job-first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sjf_prob | input | 8 | Shortest-job-first probability, in units of 1/256 |
| enq | input | NSRC | Per-source pulse: one request taken into the batch former |
| hd_valid | input | NSRC | Head request of the source's oldest formed batch is present |
| hd_bank | input | NSRC*BANK_W | Bank field of each source's head request |
| hd_last | input | NSRC | Head request is the final one of its batch |
| hd_data | input | NSRC*DATA_W | Payload of each source's head request |
| bank_full | input | NBANK | Per-bank queue full |
| pop | output | NSRC | One-hot pop strobe toward the batch former |
| bank_push | output | NBANK | One-hot push strobe into the bank queues |
| fwd_data | output | DATA_W | Payload being forwarded |
| gnt_busy | output | 1 | A granted batch is draining |
| gnt_src | output | SRC_W | Index of the granted source |
| gnt_sjf | output | 1 | The current grant came from shortest-job-first |

## Verification
On every cycle, the embedded assertions check the following: the draw register is never zero and holds still between decisions; a zero probability never yields shortest-job-first; a pick always names a ready source; pops stay one-hot and match pushes one for one; no push reaches a full bank; the grant holds during a drain and an idle gap follows its last request; and no count wraps in either direction. Only the bench scenarios can show that each winner is the right one. To do so, the bench recomputes the draw sequence, the minimum-count search and the rotation scan from its own queue model, and checks the ordering of forwarded payloads and the share of shortest-job-first decisions at a setting of 230.

// File: rtl/sms_arb_pkg.sv
package sms_arb_pkg;

  localparam int unsigned DRAW_W = 8;
  localparam logic [DRAW_W-1:0] DRAW_SEED = 8'h01;

  typedef enum logic {
    ST_PICK  = 1'b0,
    ST_DRAIN = 1'b1
  } arb_state_e;

  // maximal-length step, polynomial x^8 + x^6 + x^5 + x^4 + 1
  function automatic logic [DRAW_W-1:0] draw_step(input logic [DRAW_W-1:0] q);
    return {q[6:0], q[7] ^ q[5] ^ q[4] ^ q[3]};
  endfunction

endpackage

// File: rtl/occ_counters.sv
module occ_counters #(
  parameter int unsigned NSRC  = 4,
  parameter int unsigned CNT_W = 6,
  parameter int unsigned SRC_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSRC-1:0]       enq,
  input  logic                  dec_valid,
  input  logic [SRC_W-1:0]      dec_src,
  output logic [NSRC*CNT_W-1:0] cnt_flat
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic [CNT_W-1:0] cnt_q;
    logic             dec_hit;

    assign dec_hit = dec_valid && (dec_src == SRC_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else begin
        case ({enq[g], dec_hit})
          2'b10:   cnt_q <= cnt_q + 1'b1;
          2'b01:   cnt_q <= cnt_q - 1'b1;
          default: cnt_q <= cnt_q;
        endcase
      end
    end

    assign cnt_flat[g*CNT_W +: CNT_W] = cnt_q;

    // R10: a forward never meets an empty count, an enqueue never a full one
    a_r10_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_hit && !enq[g]) |-> (cnt_q != '0));
    a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (enq[g] && !dec_hit) |-> (cnt_q != CNT_MAX));
  end

endmodule

// File: rtl/policy_draw.sv
module policy_draw
  import sms_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [DRAW_W-1:0] prob,
  output logic [DRAW_W-1:0] draw_val,
  output logic              use_sjf
);

  logic [DRAW_W-1:0] lfsr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    lfsr_q <= DRAW_SEED;
    else if (step) lfsr_q <= draw_step(lfsr_q);
  end

  assign draw_val = lfsr_q;
  assign use_sjf  = (lfsr_q < prob);

  // R3: register never locks up at zero and moves only on a decision
  a_r3_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(lfsr_q));
  // R4: zero probability never selects shortest-job-first
  a_r4_zero_prob: assert property (@(posedge clk) disable iff (!rst_n)
    (prob == '0) |-> !use_sjf);

endmodule

// File: rtl/batch_pick.sv
module batch_pick #(
  parameter int unsigned NSRC  = 4,
  parameter int unsigned CNT_W = 6,
  parameter int unsigned SRC_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSRC-1:0]       ready,
  input  logic [NSRC*CNT_W-1:0] cnt_flat,
  input  logic [SRC_W-1:0]      rr_ptr,
  input  logic                  use_sjf,
  output logic                  any_ready,
  output logic [SRC_W-1:0]      pick
);

  // fewest outstanding, strict compare keeps the lowest index on ties
  function automatic logic [SRC_W-1:0] sjf_choose(
    input logic [NSRC-1:0]       rdy,
    input logic [NSRC*CNT_W-1:0] cnts
  );
    logic [SRC_W-1:0] best;
    logic [CNT_W-1:0] best_cnt;
    logic             found;
    best     = '0;
    best_cnt = '0;
    found    = 1'b0;
    for (int i = 0; i < int'(NSRC); i++) begin
      if (rdy[i] && (!found || (cnts[i*CNT_W +: CNT_W] < best_cnt))) begin
        best     = SRC_W'(i);
        best_cnt = cnts[i*CNT_W +: CNT_W];
        found    = 1'b1;
      end
    end
    return best;
  endfunction

  // first ready index scanning upward from the pointer, wrapping
  function automatic logic [SRC_W-1:0] rr_choose(
    input logic [NSRC-1:0]  rdy,
    input logic [SRC_W-1:0] ptr
  );
    logic [SRC_W-1:0] sel;
    logic             found;
    int               j;
    sel   = '0;
    found = 1'b0;
    for (int k = 0; k < int'(NSRC); k++) begin
      j = int'(ptr) + k;
      if (j >= int'(NSRC)) j = j - int'(NSRC);
      if (!found && rdy[j]) begin
        sel   = SRC_W'(j);
        found = 1'b1;
      end
    end
    return sel;
  endfunction

  logic [SRC_W-1:0] sjf_sel;
  logic [SRC_W-1:0] rr_sel;

  assign sjf_sel   = sjf_choose(ready, cnt_flat);
  assign rr_sel    = rr_choose(ready, rr_ptr);
  assign any_ready = |ready;
  assign pick      = use_sjf ? sjf_sel : rr_sel;

  // R2: whichever policy wins, its choice is a ready source
  a_r2_pick_ready: assert property (@(posedge clk) disable iff (!rst_n)
    any_ready |-> ready[pick]);
  a_r6_rr_ready: assert property (@(posedge clk) disable iff (!rst_n)
    any_ready |-> ready[rr_sel]);

endmodule

// File: rtl/bank_router.sv
module bank_router #(
  parameter int unsigned NBANK  = 4,
  parameter int unsigned BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [BANK_W-1:0] bank,
  output logic [NBANK-1:0]  push
);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign push[b] = fire && (bank == BANK_W'(b));
  end

  // R8: exactly one bank is pushed per forward
  a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(push));
  a_r8_fire_push: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> ($countones(push) == 1));

endmodule

// File: rtl/sms_batch_arbiter.sv
module sms_batch_arbiter
  import sms_arb_pkg::*;
#(
  parameter int unsigned NSRC   = 4,
  parameter int unsigned NBANK  = 4,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 6,
  localparam int unsigned SRC_W  = (NSRC  > 1) ? $clog2(NSRC)  : 1,
  localparam int unsigned BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [7:0]               sjf_prob,
  input  logic [NSRC-1:0]          enq,
  input  logic [NSRC-1:0]          hd_valid,
  input  logic [NSRC*BANK_W-1:0]   hd_bank,
  input  logic [NSRC-1:0]          hd_last,
  input  logic [NSRC*DATA_W-1:0]   hd_data,
  input  logic [NBANK-1:0]         bank_full,
  output logic [NSRC-1:0]          pop,
  output logic [NBANK-1:0]         bank_push,
  output logic [DATA_W-1:0]        fwd_data,
  output logic                     gnt_busy,
  output logic [SRC_W-1:0]         gnt_src,
  output logic                     gnt_sjf
);

  function automatic logic [SRC_W-1:0] rr_next(input logic [SRC_W-1:0] idx);
    return (int'(idx) == int'(NSRC) - 1) ? '0 : idx + 1'b1;
  endfunction

  arb_state_e            state_q;
  logic [SRC_W-1:0]      gsrc_q;
  logic                  gsjf_q;
  logic [SRC_W-1:0]      rr_ptr_q;

  logic [NSRC*CNT_W-1:0] cnt_flat;
  logic [DRAW_W-1:0]     draw_val;
  logic                  use_sjf;
  logic                  any_ready;
  logic [SRC_W-1:0]      pick;

  // named internal events
  logic                  pick_evt;
  logic                  head_ok;
  logic [BANK_W-1:0]     head_bank;
  logic                  head_last;
  logic                  fire;
  logic                  batch_end;

  assign pick_evt  = (state_q == ST_PICK) && any_ready;
  assign head_bank = hd_bank[gsrc_q*BANK_W +: BANK_W];
  assign head_last = hd_last[gsrc_q];
  assign head_ok   = hd_valid[gsrc_q];
  assign fire      = (state_q == ST_DRAIN) && head_ok && !bank_full[head_bank];
  assign batch_end = fire && head_last;

  occ_counters #(.NSRC(NSRC), .CNT_W(CNT_W), .SRC_W(SRC_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .enq      (enq),
    .dec_valid(fire),
    .dec_src  (gsrc_q),
    .cnt_flat (cnt_flat)
  );

  policy_draw u_draw (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (pick_evt),
    .prob    (sjf_prob),
    .draw_val(draw_val),
    .use_sjf (use_sjf)
  );

  batch_pick #(.NSRC(NSRC), .CNT_W(CNT_W), .SRC_W(SRC_W)) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .ready    (hd_valid),
    .cnt_flat (cnt_flat),
    .rr_ptr   (rr_ptr_q),
    .use_sjf  (use_sjf),
    .any_ready(any_ready),
    .pick     (pick)
  );

  bank_router #(.NBANK(NBANK), .BANK_W(BANK_W)) u_route (
    .clk  (clk),
    .rst_n(rst_n),
    .fire (fire),
    .bank (head_bank),
    .push (bank_push)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_PICK;
      gsrc_q   <= '0;
      gsjf_q   <= 1'b0;
      rr_ptr_q <= '0;
    end else begin
      case (state_q)
        ST_PICK: begin
          if (any_ready) begin
            state_q  <= ST_DRAIN;
            gsrc_q   <= pick;
            gsjf_q   <= use_sjf;
            rr_ptr_q <= rr_next(pick);
          end
        end
        ST_DRAIN: begin
          if (batch_end) state_q <= ST_PICK;
        end
        default: state_q <= ST_PICK;
      endcase
    end
  end

  always_comb begin
    pop = '0;
    if (fire) pop[gsrc_q] = 1'b1;
  end

  assign fwd_data = hd_data[gsrc_q*DATA_W +: DATA_W];
  assign gnt_busy = (state_q == ST_DRAIN);
  assign gnt_src  = gsrc_q;
  assign gnt_sjf  = gsjf_q;

  // R9: a full bank never receives a push
  a_r9_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_push & bank_full) == '0);
  // R8: pushes and pops pair one for one
  a_r8_push_pop: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bank_push) == $countones(pop));
  // R7: pops are one-hot and happen only during a drain
  a_r7_pop_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pop) && ((pop == '0) || gnt_busy));
  a_r7_grant_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_busy && !batch_end) |=> (gnt_busy && $stable(gnt_src) && $stable(gnt_sjf)));
  a_r7_gap: assert property (@(posedge clk) disable iff (!rst_n)
    batch_end |=> !gnt_busy);
  // R4: a zero probability yields only rotation grants
  a_r4_rr_only: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_evt && (sjf_prob == 8'd0)) |=> !gnt_sjf);

endmodule

// File: tb/tb_sms_batch_arbiter.sv
`timescale 1ns/1ps
module tb_sms_batch_arbiter;

  localparam int NSRC = 4;
  localparam int NBANK = 4;
  localparam int DATA_W = 16;
  localparam int QMAX = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] sjf_prob = 8'd0;
  logic [NSRC-1:0] enq = '0;
  logic [NSRC-1:0] hd_valid = '0;
  logic [NSRC*2-1:0] hd_bank = '0;
  logic [NSRC-1:0] hd_last = '0;
  logic [NSRC*DATA_W-1:0] hd_data = '0;
  logic [NBANK-1:0] bank_full = '0;
  logic [NSRC-1:0] pop;
  logic [NBANK-1:0] bank_push;
  logic [DATA_W-1:0] fwd_data;
  logic gnt_busy;
  logic [1:0] gnt_src;
  logic gnt_sjf;

  always #4 clk = ~clk;

  sms_batch_arbiter #(.NSRC(NSRC), .NBANK(NBANK), .DATA_W(DATA_W), .CNT_W(6)) dut (
    .clk(clk), .rst_n(rst_n), .sjf_prob(sjf_prob), .enq(enq),
    .hd_valid(hd_valid), .hd_bank(hd_bank), .hd_last(hd_last), .hd_data(hd_data),
    .bank_full(bank_full), .pop(pop), .bank_push(bank_push), .fwd_data(fwd_data),
    .gnt_busy(gnt_busy), .gnt_src(gnt_src), .gnt_sjf(gnt_sjf)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // bench queue model
  int qlen [NSRC];
  int qptr [NSRC];
  bit qlast [NSRC][QMAX];
  int scen = 0;

  // bench model of arbiter-visible state
  logic [7:0] m_draw = 8'h01;
  int m_ptr = 0;
  int cur_src = 0;
  bit exp_pend = 0;
  int exp_src = 0;
  bit exp_sjf = 0;
  bit exp_gap = 0;
  int n_dec = 0;
  int n_sjf = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  function automatic int bank_of(int s, int i);
    return (s * 3 + i + scen) % NBANK;
  endfunction

  function automatic logic [DATA_W-1:0] data_of(int s, int i);
    return DATA_W'((s << 12) | (scen << 8) | i);
  endfunction

  task automatic add_batch(int s, int len);
    for (int i = 0; i < len; i++) begin
      qlast[s][qlen[s] + i] = (i == len - 1);
    end
    qlen[s] += len;
  endtask

  task automatic clear_queues();
    for (int s = 0; s < NSRC; s++) begin
      qlen[s] = 0;
      qptr[s] = 0;
    end
  endtask

  // R10: one enqueue pulse per request into the outstanding counts
  task automatic enqueue_all();
    int mx;
    mx = 0;
    for (int s = 0; s < NSRC; s++) if (qlen[s] > mx) mx = qlen[s];
    for (int k = 0; k < mx; k++) begin
      @(negedge clk);
      for (int s = 0; s < NSRC; s++) enq[s] = (k < qlen[s]);
    end
    @(negedge clk);
    enq = '0;
  endtask

  task automatic drive_heads();
    for (int s = 0; s < NSRC; s++) begin
      hd_valid[s] = (qptr[s] < qlen[s]);
      hd_bank[s*2 +: 2] = 2'(bank_of(s, qptr[s]));
      hd_last[s] = (qptr[s] < qlen[s]) ? qlast[s][qptr[s]] : 1'b0;
      hd_data[s*DATA_W +: DATA_W] = data_of(s, qptr[s]);
    end
  endtask

  function automatic bit all_drained();
    for (int s = 0; s < NSRC; s++) if (qptr[s] < qlen[s]) return 0;
    return 1;
  endfunction

  function automatic logic [7:0] model_step(logic [7:0] q);
    return {q[6:0], ^(q & 8'hB8)};
  endfunction

  function automatic logic [NBANK-1:0] full_pat(int mode, int cyc);
    if (mode == 0) return '0;
    if (cyc % 3 != 0) return 4'(1 << (cyc % 4));
    return '0;
  endfunction

  task automatic run(int mode, int maxc);
    int remaining;
    int cnt;
    int bk;
    bit fire_exp;
    int best;
    int bestc;
    int j;
    for (int cyc = 0; cyc < maxc; cyc++) begin
      @(negedge clk);
      drive_heads();
      bank_full = full_pat(mode, cyc);
      #1;
      if (exp_gap) begin
        check(gnt_busy == 1'b0, "R7 gap after last", int'(gnt_busy), 0);
        exp_gap = 0;
      end
      if (exp_pend) begin
        check(gnt_busy == 1'b1, "R2 grant taken", int'(gnt_busy), 1);
        check(int'(gnt_sjf) == int'(exp_sjf), "R3 policy draw", int'(gnt_sjf), int'(exp_sjf));
        check(int'(gnt_src) == exp_src, exp_sjf ? "R5 sjf winner" : "R6 rr winner",
              int'(gnt_src), exp_src);
        exp_pend = 0;
        cur_src = exp_src;
      end
      if (!gnt_busy) begin
        check(pop == '0 && bank_push == '0, "R7 idle quiet", int'(pop), 0);
        if (hd_valid != '0) begin
          exp_sjf = (m_draw < sjf_prob);
          if (exp_sjf) begin
            best = -1; bestc = 0;
            for (int s = 0; s < NSRC; s++) begin
              remaining = qlen[s] - qptr[s];
              if (hd_valid[s] && (best < 0 || remaining < bestc)) begin
                best = s; bestc = remaining;
              end
            end
            exp_src = best;
          end else begin
            exp_src = -1;
            for (int k = 0; k < NSRC; k++) begin
              j = (m_ptr + k) % NSRC;
              if (exp_src < 0 && hd_valid[j]) exp_src = j;
            end
          end
          m_draw = model_step(m_draw);
          m_ptr = (exp_src + 1) % NSRC;
          exp_pend = 1;
          n_dec++;
          if (exp_sjf) n_sjf++;
        end else if (all_drained()) begin
          break;
        end
      end else begin
        check(int'(gnt_src) == cur_src, "R7 grant stable", int'(gnt_src), cur_src);
        bk = bank_of(cur_src, qptr[cur_src]);
        fire_exp = (qptr[cur_src] < qlen[cur_src]) && !bank_full[bk];
        cnt = fire_exp ? (1 << cur_src) : 0;
        check(int'(pop) == cnt, bank_full[bk] ? "R9 stall on full" : "R7 pop", int'(pop), cnt);
        cnt = fire_exp ? (1 << bk) : 0;
        check(int'(bank_push) == cnt, "R8 bank routing", int'(bank_push), cnt);
        if (fire_exp) begin
          check(fwd_data == data_of(cur_src, qptr[cur_src]), "R8 payload",
                int'(fwd_data), int'(data_of(cur_src, qptr[cur_src])));
          if (qlast[cur_src][qptr[cur_src]]) exp_gap = 1;
          qptr[cur_src]++;
        end
      end
    end
    check(all_drained() && !gnt_busy, "R7 all batches drained", int'(gnt_busy), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL R7 watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    clear_queues();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    check(gnt_busy == 1'b0, "R1 reset busy", int'(gnt_busy), 0);
    check(pop == '0 && bank_push == '0, "R1 reset strobes", int'(pop), 0);

    // scenario 0: pure rotation
    scen = 0;
    sjf_prob = 8'd0;
    add_batch(0, 2); add_batch(0, 1); add_batch(0, 3);
    add_batch(1, 4);
    add_batch(2, 1); add_batch(2, 1);
    add_batch(3, 2); add_batch(3, 2);
    enqueue_all();
    n_dec = 0; n_sjf = 0;
    run(0, 400);
    check(n_sjf == 0, "R4 zero prob never sjf", n_sjf, 0);

    // scenario 1: near-certain SJF with bank stalls
    scen = 1;
    clear_queues();
    sjf_prob = 8'd255;
    add_batch(0, 6);
    add_batch(1, 1); add_batch(1, 1); add_batch(1, 1);
    add_batch(2, 3); add_batch(2, 2);
    add_batch(3, 2);
    enqueue_all();
    run(1, 600);

    // scenario 2: equal counts exercise the tie rule, then p=230 statistics
    scen = 2;
    clear_queues();
    sjf_prob = 8'd230;
    for (int s = 0; s < NSRC; s++) add_batch(s, 2);
    enqueue_all();
    run(0, 200);

    scen = 3;
    clear_queues();
    for (int s = 0; s < NSRC; s++)
      for (int b = 0; b < 10; b++) add_batch(s, 1 + ((s + b) % 2));
    enqueue_all();
    n_dec = 0; n_sjf = 0;
    run(1, 2000);
    check(n_sjf * 10 >= n_dec * 7, "R11 p=230 mostly sjf", n_sjf, n_dec);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule